// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a small controller between its running state and three reduced-power states. A 16-bit control word selects the target state, sets how long the selected wake pin must stay low before a standby wake is accepted, and allows or blocks watchdog wakes from standby. When the processor issues an idle request, the sequencer moves to the selected state. It then drives enables for the oscillator, the PLL and the processor clock.

Three wake sources reach the block. The first is one selected active-low pin. The second is an active-low external wake that behaves like a reset line. The third is a watchdog request. The light idle state leaves on any source. Standby qualifies the pin against a programmable low-level run. The deep halt state stops every clock. It restarts them in a strict chain: the oscillator first, then the PLL once the oscillator reports stable, then the processor clock together with a one-cycle wake interrupt once the PLL reports lock. Halt entry is refused while the clock system reports limp mode.

The oscillator, the PLL and the interrupt controller are outside the block. They appear only as enable outputs and handshake inputs. In simulation `clk` stands for the oscillator clock and keeps running.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the control word reads 0x00FC (mode 00, qualification field all ones, watchdog-wake enable 0). The state output is 0 (ACTIVE). `osc_en`, `pll_en` and `cpu_clk_en` are 1 and `wake_irq` is 0.
- R2: A write with `cfg_we` high stores bit 15 (watchdog-wake enable), bits 7:2 (qualification field q) and bits 1:0 (mode). Bits 14:8 always read 0. The new value is visible on `cfg_rdata` after the write edge.
- R3: An `idle_req` in ACTIVE moves the block at the next edge to the state the mode selects. Mode 00 selects IDLE (state 1), 01 selects STANDBY (state 2), and 10 or 11 selects HALT (state 3). `cpu_clk_en` is 0 in all three states.
- R4: An `idle_req` with mode 10 or 11 while `limp_mode` is 1 is ignored. The block stays in ACTIVE (state 0) with all enables at 1.
- R5: In HALT with no wake present, `osc_en`, `pll_en` and `cpu_clk_en` are all 0.
- R6: In HALT, a low level on `gpio_wake_n` or `ext_wake_n` raises `osc_en` at once, before any clock edge. The synchronized wake then moves the block to oscillator start-up (state 4) with `pll_en` still 0. `pll_en` rises only after `osc_stable` is seen (state 5). `cpu_clk_en` and `wake_irq` rise only after `pll_locked` is seen (state 6).
- R7: If the wake level is released during oscillator start-up, before `osc_stable`, the block returns to HALT (state 3) and `osc_en` falls to 0.
- R8: In STANDBY, `osc_en` and `pll_en` stay 1. The wake pin must be low for q+2 consecutive edges. A run of q+1 edges gives no wake. After a level held from edge 1 onwards, the wake (state 6, `wake_irq` 1) appears at edge q+4, which counts the two synchronizer edges.
- R9: In STANDBY, `wdog_wake` causes a wake at the next edge only when bit 15 is 1. Otherwise it is ignored.
- R10: `wake_irq` is high for exactly one cycle (state 6). The next edge returns the block to ACTIVE with the control word unchanged.
- R11: In IDLE, the synchronized pin, the synchronized external wake and `wdog_wake` each cause a wake without qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read value |
| idle_req | input | 1 | Processor idle request, one cycle |
| limp_mode | input | 1 | Clock system running in limp mode |
| gpio_wake_n | input | 1 | Selected wake pin, active low, asynchronous |
| ext_wake_n | input | 1 | External reset-style wake, active low, asynchronous |
| wdog_wake | input | 1 | Watchdog wake request, synchronous |
| osc_stable | input | 1 | Oscillator reports stable |
| pll_locked | input | 1 | PLL reports lock |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| lp_state | output | 3 | Sequencer state code |

## Verification
A wrong qualification count shifts the standby wake edge away from q+4. It also lets a q+1 run wake the block. The sweep over every q value exposes both at the exact edge. A broken halt chain shows up as `pll_en` or `cpu_clk_en` rising one edge after the state leaves oscillator start-up with the handshake still low. A stuck wake latch shows up as `osc_en` staying high three edges after the pin is released. A lost limp check or watchdog enable shows up on the state output in the cycle after the request.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam int CFG_W    = 16;
   localparam int WDE_BIT  = 15;
   localparam int QUAL_LSB = 2;
   localparam int MODE_W   = 2;

   typedef enum logic [2:0] {
      ST_ACTIVE = 3'd0,
      ST_IDLE   = 3'd1,
      ST_STBY   = 3'd2,
      ST_HOFF   = 3'd3,
      ST_HOSC   = 3'd4,
      ST_HPLL   = 3'd5,
      ST_WAKE   = 3'd6
   } lp_state_e;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lpm_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("lpm_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
   import lpm_pkg::*;
#(
   parameter int QUAL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_W-1:0]  wdata,
   output logic [CFG_W-1:0]  rdata,
   output logic              wd_en,
   output logic [QUAL_W-1:0] qual,
   output logic [MODE_W-1:0] mode
);
   if (QUAL_W < 1 || QUAL_LSB + QUAL_W > WDE_BIT) begin : g_bad_qual
      $error("lpm_cfg_reg: QUAL_W does not fit the control word");
   end

   localparam logic [CFG_W-1:0] QUAL_MASK = CFG_W'(((1 << QUAL_W) - 1) << QUAL_LSB);
   localparam logic [CFG_W-1:0] MODE_MASK = CFG_W'((1 << MODE_W) - 1);
   localparam logic [CFG_W-1:0] WDE_MASK  = CFG_W'(1) << WDE_BIT;
   localparam logic [CFG_W-1:0] KEEP_MASK = QUAL_MASK | MODE_MASK | WDE_MASK;
   localparam logic [CFG_W-1:0] RST_VAL   = QUAL_MASK;

   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= RST_VAL;
      else if (we) word_q <= wdata & KEEP_MASK;
   end

   assign rdata = word_q;
   assign wd_en = word_q[WDE_BIT];
   assign qual  = word_q[QUAL_LSB +: QUAL_W];
   assign mode  = word_q[MODE_W-1:0];

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~KEEP_MASK) == '0);
endmodule

// File: rtl/lpm_qual_cnt.sv
module lpm_qual_cnt #(
   parameter int QUAL_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              lvl,
   input  logic [QUAL_W-1:0] qual,
   output logic              done
);
   localparam int CNT_W = QUAL_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;

   assign target = CNT_W'(qual) + CNT_W'(1);
   assign done   = run && lvl && (cnt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (run && lvl && !done) cnt <= cnt + CNT_W'(1);
      else                          cnt <= '0;
   end

   // R8
   qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lvl && $past(lvl)));
endmodule

// File: rtl/lpm_wake_latch.sv
module lpm_wake_latch #(
   parameter bit ASYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   if (ASYNC) begin : g_async
      always_ff @(posedge clk or negedge rst_n or posedge set) begin
         if (!rst_n)   q <= 1'b0;
         else if (set) q <= 1'b1;
         else if (clr) q <= 1'b0;
      end
   end else begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= 1'b0;
         else if (set) q <= 1'b1;
         else if (clr) q <= 1'b0;
      end
   end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int QUAL_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit ASYNC_WAKE  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   output logic [15:0] cfg_rdata,
   input  logic        idle_req,
   input  logic        limp_mode,
   input  logic        gpio_wake_n,
   input  logic        ext_wake_n,
   input  logic        wdog_wake,
   input  logic        osc_stable,
   input  logic        pll_locked,
   output logic        osc_en,
   output logic        pll_en,
   output logic        cpu_clk_en,
   output logic        wake_irq,
   output logic [2:0]  lp_state
);
   lp_state_e         st, st_nxt;
   logic              wd_en;
   logic [QUAL_W-1:0] qual;
   logic [MODE_W-1:0] mode;
   logic [1:0]        wake_s;
   logic              g_s, e_s, any_s;
   logic              q_done;
   logic              halt_arm_q;
   logic              raw_wake, latch_set, latch_q;
   logic              in_halt_off;

   lpm_cfg_reg #(.QUAL_W(QUAL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .wd_en(wd_en), .qual(qual), .mode(mode));

   lpm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({~ext_wake_n, ~gpio_wake_n}), .q(wake_s));

   assign g_s   = wake_s[0];
   assign e_s   = wake_s[1];
   assign any_s = g_s | e_s;

   lpm_qual_cnt #(.QUAL_W(QUAL_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .run(st == ST_STBY), .lvl(g_s),
      .qual(qual), .done(q_done));

   assign raw_wake  = ~gpio_wake_n | ~ext_wake_n;
   assign latch_set = halt_arm_q & raw_wake;

   lpm_wake_latch #(.ASYNC(ASYNC_WAKE)) u_latch (
      .clk(clk), .rst_n(rst_n), .set(latch_set), .clr(~any_s), .q(latch_q));

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_ACTIVE: if (idle_req) begin
            if (mode == 2'b00)      st_nxt = ST_IDLE;
            else if (mode == 2'b01) st_nxt = ST_STBY;
            else if (!limp_mode)    st_nxt = ST_HOFF;
         end
         ST_IDLE:   if (any_s || wdog_wake) st_nxt = ST_WAKE;
         ST_STBY:   if (q_done || e_s || (wdog_wake && wd_en)) st_nxt = ST_WAKE;
         ST_HOFF:   if (any_s) st_nxt = ST_HOSC;
         ST_HOSC:   if (!any_s) st_nxt = ST_HOFF;
                    else if (osc_stable) st_nxt = ST_HPLL;
         ST_HPLL:   if (pll_locked) st_nxt = ST_WAKE;
         ST_WAKE:   st_nxt = ST_ACTIVE;
         default:   st_nxt = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_ACTIVE;
         halt_arm_q <= 1'b0;
      end else begin
         st         <= st_nxt;
         halt_arm_q <= (st_nxt == ST_HOFF);
      end
   end

   assign in_halt_off = (st == ST_HOFF) || (st == ST_HOSC);
   assign osc_en      = in_halt_off ? latch_q : 1'b1;
   assign pll_en      = !in_halt_off;
   assign cpu_clk_en  = (st == ST_ACTIVE) || (st == ST_WAKE);
   assign wake_irq    = (st == ST_WAKE);
   assign lp_state    = st;

   // R4
   limp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACTIVE && idle_req && mode[1] && limp_mode) |=> (lp_state == 3'd0));
   // R5
   halt_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == 3'd3) |-> (!pll_en && !cpu_clk_en));
   // R6
   pll_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pll_en) && $past(st == ST_HOSC)) |-> $past(osc_stable));
   // R6
   cpu_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(st == ST_HPLL)) |-> $past(pll_locked));
   // R9
   wdog_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STBY && !wd_en && wdog_wake && !q_done && !e_s) |=> (lp_state == 3'd2));
   // R10
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> (!wake_irq && lp_state == 3'd0 && $stable(cfg_rdata)));
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        idle_req = 1'b0;
   logic        limp_mode = 1'b0;
   logic        gpio_wake_n = 1'b1;
   logic        ext_wake_n = 1'b1;
   logic        wdog_wake = 1'b0;
   logic        osc_stable = 1'b0;
   logic        pll_locked = 1'b0;
   logic        osc_en, pll_en, cpu_clk_en, wake_irq;
   logic [2:0]  lp_state;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lpm_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .idle_req(idle_req), .limp_mode(limp_mode),
      .gpio_wake_n(gpio_wake_n), .ext_wake_n(ext_wake_n), .wdog_wake(wdog_wake),
      .osc_stable(osc_stable), .pll_locked(pll_locked), .osc_en(osc_en),
      .pll_en(pll_en), .cpu_clk_en(cpu_clk_en), .wake_irq(wake_irq),
      .lp_state(lp_state));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] v);
      cfg_we = 1'b1;
      cfg_wdata = v;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic go_idle();
      idle_req = 1'b1;
      tick();
      idle_req = 1'b0;
   endtask

   task automatic enables(string tag, logic [2:0] exp);
      chk(tag, {29'd0, osc_en, pll_en, cpu_clk_en}, {29'd0, exp});
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 cfg", cfg_rdata, 16'h00FC);
      chk("R1 state", lp_state, 0);
      enables("R1 enables", 3'b111);
      chk("R1 irq", wake_irq, 0);

      // R2 register patterns
      for (int i = 0; i < 6; i++) begin
         logic [15:0] v;
         v = 16'hFFFF >> (i * 3);
         v = v ^ (16'hA5C3 << i);
         wr(v);
         chk("R2 readback", cfg_rdata, v & 16'h80FF);
      end

      // R3 / R11 IDLE exits
      for (int src = 0; src < 3; src++) begin
         int n;
         wr(16'h0000);
         go_idle();
         chk("R3 idle state", lp_state, 1);
         enables("R3 idle enables", 3'b110);
         if (src == 0) gpio_wake_n = 1'b0;
         else if (src == 1) ext_wake_n = 1'b0;
         else wdog_wake = 1'b1;
         n = 0;
         do begin tick(); n++; end while (!wake_irq && n < 20);
         chk("R11 idle wake latency", n, (src == 2) ? 1 : 3);
         gpio_wake_n = 1'b1; ext_wake_n = 1'b1; wdog_wake = 1'b0;
         tick();
         chk("R10 back to active", lp_state, 0);
         chk("R10 irq low", wake_irq, 0);
         repeat (3) tick();
      end

      // R4 limp refusal
      for (int m = 2; m < 4; m++) begin
         wr(16'h00FC | 16'(m));
         limp_mode = 1'b1;
         go_idle();
         tick();
         chk("R4 limp state", lp_state, 0);
         enables("R4 limp enables", 3'b111);
         limp_mode = 1'b0;
      end

      // R3 / R5 HALT entry
      wr(16'h00FE);
      go_idle();
      chk("R3 halt state", lp_state, 3);
      repeat (4) tick();
      enables("R5 halt dark", 3'b000);

      // R6 async oscillator start, then R7 abort
      gpio_wake_n = 1'b0;
      #1;
      chk("R6 osc async", osc_en, 1);
      @(negedge clk);
      repeat (3) tick();
      chk("R6 osc phase", lp_state, 4);
      chk("R6 pll held", pll_en, 0);
      gpio_wake_n = 1'b1;
      repeat (3) tick();
      chk("R7 abort state", lp_state, 3);
      chk("R7 osc off", osc_en, 0);

      // R6 full chain via external wake
      ext_wake_n = 1'b0;
      repeat (3) tick();
      chk("R6 ext osc phase", lp_state, 4);
      osc_stable = 1'b1;
      tick();
      chk("R6 pll phase", lp_state, 5);
      enables("R6 pll enables", 3'b110);
      repeat (3) tick();
      chk("R6 cpu held", cpu_clk_en, 0);
      pll_locked = 1'b1;
      tick();
      chk("R6 wake state", lp_state, 6);
      chk("R6 irq", wake_irq, 1);
      chk("R6 cpu on", cpu_clk_en, 1);
      tick();
      chk("R10 active", lp_state, 0);
      chk("R10 irq pulse", wake_irq, 0);
      chk("R10 cfg kept", cfg_rdata, 16'h00FE);
      ext_wake_n = 1'b1; osc_stable = 1'b0; pll_locked = 1'b0;
      repeat (3) tick();

      // R3 mode 11 also selects HALT
      wr(16'h00FF);
      go_idle();
      chk("R3 halt mode 11", lp_state, 3);
      ext_wake_n = 1'b0;
      repeat (3) tick();
      osc_stable = 1'b1; pll_locked = 1'b1;
      repeat (3) tick();
      chk("R10 after halt", lp_state, 0);
      ext_wake_n = 1'b1; osc_stable = 1'b0; pll_locked = 1'b0;
      repeat (3) tick();

      // R8 qualification sweep
      for (int q = 0; q < 64; q++) begin
         int n;
         wr(16'(q << 2) | 16'h0001);
         go_idle();
         chk("R8 stby state", lp_state, 2);
         enables("R8 stby enables", 3'b110);
         gpio_wake_n = 1'b0;
         repeat (q + 1) tick();
         gpio_wake_n = 1'b1;
         repeat (5) tick();
         chk("R8 short run ignored", lp_state, 2);
         gpio_wake_n = 1'b0;
         n = 0;
         do begin tick(); n++; end while (!wake_irq && n < 200);
         chk("R8 wake latency", n, q + 4);
         gpio_wake_n = 1'b1;
         tick();
         chk("R10 stby return", lp_state, 0);
         repeat (3) tick();
      end

      // R9 watchdog gated by enable bit
      wr(16'h0001);
      go_idle();
      wdog_wake = 1'b1;
      tick();
      wdog_wake = 1'b0;
      tick();
      chk("R9 wdog blocked", lp_state, 2);
      ext_wake_n = 1'b0;
      repeat (3) tick();
      chk("R9 ext leaves stby", wake_irq, 1);
      ext_wake_n = 1'b1;
      repeat (4) tick();
      wr(16'h8001);
      go_idle();
      wdog_wake = 1'b1;
      tick();
      wdog_wake = 1'b0;
      chk("R9 wdog accepted", lp_state, 6);
      tick();
      chk("R10 wdog return", lp_state, 0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule